// File: doc/BRIEF.md
# Memory Error Syndrome Logger

This block keeps a 64-bit syndrome word for a group of cache RAMs. It records where the first memory error was reported and then counts the errors that follow. Each RAM has its own report port: a valid strobe, a bank number, a way (or CPU/way) code, an index and an abort flag. Error detection itself happens in the RAMs' own checking logic. Software reads the word directly and clears it with a write strobe.

The first report after a clear fills the location fields and sets the sticky Valid bit. Later reports are sorted by comparing them with the stored location. A report that matches the stored RAM, bank, way and index is counted as a repeat. Any other report is counted as an other-error. Reports on several ports in the same cycle are merged into one event. The lowest port number wins the capture, and each counter moves by at most one per cycle. Both counters stop at their maximum value.

Top module: `mem_err_logger`

## Requirements
- R1: After reset, `syn_word` reads all zeros.
- R2: When `clr_wr` is high, the word reads zero after the next clock edge. This holds even if error reports arrive in the same cycle, because the clear takes priority.
- R3: Bit 31 (Valid) is set by the first accepted report and stays set until a clear.
- R4: Bit 63 (Fatal) is set by any accepted report whose abort flag is high. It stays set until a clear, and it is never set while Valid is clear.
- R5: On the first report, the word records the location and zeros both counts. The RAM code goes in [30:24], the way code in [21:18] and the index in [17:0]. The way code is stored unchanged, so for the snoop RAM, bits [20:19] give the CPU and bit 18 gives the way.
- R6: The port number sets the RAM code. Port 0 is tag (7'h10), port 1 is data (7'h11), port 2 is snoop tag (7'h12), port 3 is dirty (7'h14) and port 4 is replacement state (7'h18).
- R7: While Valid is set, a report whose RAM, bank, way and index all equal the stored values increments the repeat count in [39:32]. A report that differs only in bank is not a repeat.
- R8: While Valid is set, the other-error count in [47:40] increases by exactly one in any cycle that has at least one non-matching report, however many such reports there are. A matching report and a non-matching report in the same cycle each bump their own count.
- R9: When first reports arrive on several ports in one cycle, the lowest-numbered port is captured and the other-error count becomes 1.
- R10: Both counts saturate at 255 and never wrap.
- R11: Bits [62:48] and [23:22] always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rep_vld | input | N_RAM | One report strobe per RAM port |
| rep_bank | input | N_RAM*BANK_W | Bank of each report, packed by port |
| rep_way | input | N_RAM*WAY_W | Way or CPU/way code of each report |
| rep_idx | input | N_RAM*IDX_W | Index of each report |
| rep_abort | input | N_RAM | Report caused a data abort |
| clr_wr | input | 1 | Software write; clears the word |
| syn_word | output | 64 | Syndrome word read by software |

## Verification
The capture path is tested with single reports on each port, which separates the five RAM codes and the field positions. Repeated identical reports are compared with reports that change only the bank or only the index, which separates the repeat path from the other-error path. Two reports in one cycle are tested in three mixes: both first, both non-matching, and one matching with one not. These show whether arbitration picks the lowest port and whether the counts collapse to one per cycle. Long runs of reports exercise saturation, and a clear in the same cycle as a report checks clear priority.

// File: rtl/mel_pkg.sv
package mel_pkg;
   localparam int SYN_W      = 64;
   localparam int RAM_CODE_W = 7;
   localparam int FATAL_BIT  = 63;
   localparam int OTH_LSB    = 40;
   localparam int REP_LSB    = 32;
   localparam int VALID_BIT  = 31;
   localparam int RAM_LSB    = 24;
   localparam int WAY_LSB    = 18;
   localparam int IDX_LSB    = 0;
   localparam int MAX_PORTS  = 5;
   localparam int FIELD_CNT_W = 8;
   localparam int FIELD_WAY_W = 4;
   localparam int FIELD_IDX_W = 18;

   typedef enum logic [RAM_CODE_W-1:0] {
      RAM_TAG   = 7'h10,
      RAM_DATA  = 7'h11,
      RAM_SNOOP = 7'h12,
      RAM_DIRTY = 7'h14,
      RAM_REPL  = 7'h18
   } ram_code_e;

   function automatic logic [RAM_CODE_W-1:0] port_code(input int p);
      case (p)
         0:       port_code = RAM_TAG;
         1:       port_code = RAM_DATA;
         2:       port_code = RAM_SNOOP;
         3:       port_code = RAM_DIRTY;
         default: port_code = RAM_REPL;
      endcase
   endfunction
endpackage

// File: rtl/mel_prio_arb.sv
module mel_prio_arb #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any,
   output logic         multi
);
   always_comb begin
      grant = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
         end
      end
   end

   assign any   = |req;
   assign multi = |(req & (req - 1'b1));

   a_r9_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~req) == '0));
   a_r9_grant_when_req: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> (grant != '0));
endmodule

// File: rtl/mel_loc_match.sv
module mel_loc_match import mel_pkg::*; #(
   parameter int N      = 5,
   parameter int BANK_W = 2,
   parameter int WAY_W  = 4,
   parameter int IDX_W  = 18
) (
   input  logic [N-1:0]        req,
   input  logic [N*BANK_W-1:0] bank,
   input  logic [N*WAY_W-1:0]  way,
   input  logic [N*IDX_W-1:0]  idx,
   input  logic [RAM_CODE_W-1:0] cap_ram,
   input  logic [BANK_W-1:0]   cap_bank,
   input  logic [WAY_W-1:0]    cap_way,
   input  logic [IDX_W-1:0]    cap_idx,
   output logic                hit_any,
   output logic                miss_any
);
   logic [N-1:0] hit;
   logic [N-1:0] miss;

   for (genvar g = 0; g < N; g++) begin : g_port
      localparam logic [RAM_CODE_W-1:0] CODE = port_code(g);
      logic same;
      assign same = (CODE == cap_ram)
                 && (bank[g*BANK_W +: BANK_W] == cap_bank)
                 && (way[g*WAY_W +: WAY_W]    == cap_way)
                 && (idx[g*IDX_W +: IDX_W]    == cap_idx);
      assign hit[g]  = req[g] &  same;
      assign miss[g] = req[g] & ~same;
   end

   assign hit_any  = |hit;
   assign miss_any = |miss;
endmodule

// File: rtl/mel_sat_cnt.sv
module mel_sat_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         restart,
   input  logic         seed,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] MAX = {W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         cnt <= '0;
      else if (restart)
         cnt <= {{(W-1){1'b0}}, seed};
      else if (inc && cnt != MAX)
         cnt <= cnt + 1'b1;
   end

   a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == MAX && !clr && !restart) |=> cnt == MAX);
   a_r8_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !restart) |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/mem_err_logger.sv
module mem_err_logger import mel_pkg::*; #(
   parameter int N_RAM  = 5,
   parameter int BANK_W = 2,
   parameter int WAY_W  = 4,
   parameter int IDX_W  = 18,
   parameter int CNT_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_RAM-1:0]        rep_vld,
   input  logic [N_RAM*BANK_W-1:0] rep_bank,
   input  logic [N_RAM*WAY_W-1:0]  rep_way,
   input  logic [N_RAM*IDX_W-1:0]  rep_idx,
   input  logic [N_RAM-1:0]        rep_abort,
   input  logic                    clr_wr,
   output logic [SYN_W-1:0]        syn_word
);
   if (N_RAM < 1 || N_RAM > MAX_PORTS) begin : g_bad_ports
      $error("mem_err_logger: N_RAM out of range");
   end
   if (WAY_W > FIELD_WAY_W || IDX_W > FIELD_IDX_W) begin : g_bad_loc
      $error("mem_err_logger: way or index wider than its field");
   end
   if (CNT_W != FIELD_CNT_W) begin : g_bad_cnt
      $error("mem_err_logger: counter width must match its field");
   end

   logic [N_RAM-1:0]      grant;
   logic                  any_req, multi_req;
   logic                  hit_any, miss_any;
   logic                  valid_q, fatal_q;
   logic [RAM_CODE_W-1:0] ram_q, sel_ram;
   logic [BANK_W-1:0]     bank_q, sel_bank;
   logic [WAY_W-1:0]      way_q, sel_way;
   logic [IDX_W-1:0]      idx_q, sel_idx;
   logic [CNT_W-1:0]      rep_cnt, oth_cnt;
   logic                  capture;

   mel_prio_arb #(.N(N_RAM)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(rep_vld),
      .grant(grant), .any(any_req), .multi(multi_req));

   mel_loc_match #(.N(N_RAM), .BANK_W(BANK_W), .WAY_W(WAY_W), .IDX_W(IDX_W)) u_match (
      .req(rep_vld), .bank(rep_bank), .way(rep_way), .idx(rep_idx),
      .cap_ram(ram_q), .cap_bank(bank_q), .cap_way(way_q), .cap_idx(idx_q),
      .hit_any(hit_any), .miss_any(miss_any));

   always_comb begin
      sel_ram  = '0;
      sel_bank = '0;
      sel_way  = '0;
      sel_idx  = '0;
      for (int i = 0; i < N_RAM; i++) begin
         if (grant[i]) begin
            sel_ram  = port_code(i);
            sel_bank = rep_bank[i*BANK_W +: BANK_W];
            sel_way  = rep_way[i*WAY_W +: WAY_W];
            sel_idx  = rep_idx[i*IDX_W +: IDX_W];
         end
      end
   end

   assign capture = any_req & ~valid_q & ~clr_wr;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_wr) begin
         valid_q <= 1'b0;
         fatal_q <= 1'b0;
         ram_q   <= '0;
         bank_q  <= '0;
         way_q   <= '0;
         idx_q   <= '0;
      end else begin
         if (any_req) valid_q <= 1'b1;
         if (|(rep_vld & rep_abort)) fatal_q <= 1'b1;
         if (capture) begin
            ram_q  <= sel_ram;
            bank_q <= sel_bank;
            way_q  <= sel_way;
            idx_q  <= sel_idx;
         end
      end
   end

   mel_sat_cnt #(.W(CNT_W)) u_rep_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_wr), .restart(capture),
      .seed(1'b0), .inc(valid_q & hit_any), .cnt(rep_cnt));

   mel_sat_cnt #(.W(CNT_W)) u_oth_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_wr), .restart(capture),
      .seed(multi_req), .inc(valid_q & miss_any), .cnt(oth_cnt));

   always_comb begin
      syn_word = '0;
      syn_word[FATAL_BIT]               = fatal_q;
      syn_word[OTH_LSB +: CNT_W]        = oth_cnt;
      syn_word[REP_LSB +: CNT_W]        = rep_cnt;
      syn_word[VALID_BIT]               = valid_q;
      syn_word[RAM_LSB +: RAM_CODE_W]   = ram_q;
      syn_word[WAY_LSB +: WAY_W]        = way_q;
      syn_word[IDX_LSB +: IDX_W]        = idx_q;
   end

   a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> syn_word == '0);
   a_r3_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (syn_word[VALID_BIT] && !clr_wr) |=> syn_word[VALID_BIT]);
   a_r3_valid_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ((rep_vld != '0) && !clr_wr) |=> syn_word[VALID_BIT]);
   a_r4_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (syn_word[FATAL_BIT] && !clr_wr) |=> syn_word[FATAL_BIT]);
   a_r4_fatal_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
      syn_word[FATAL_BIT] |-> syn_word[VALID_BIT]);
   a_r5_location_held: assert property (@(posedge clk) disable iff (!rst_n)
      (syn_word[VALID_BIT] && !clr_wr) |=> $stable(syn_word[30:0]));
   a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      syn_word[62:48] == '0 && syn_word[23:22] == '0);
endmodule

// File: tb/mem_err_logger_tb.sv
module mem_err_logger_tb;
   localparam int N = 5, BW = 2, WW = 4, IW = 18;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N-1:0]      rep_vld = '0;
   logic [N*BW-1:0]   rep_bank = '0;
   logic [N*WW-1:0]   rep_way = '0;
   logic [N*IW-1:0]   rep_idx = '0;
   logic [N-1:0]      rep_abort = '0;
   logic              clr_wr = 1'b0;
   logic [63:0]       syn_word;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mem_err_logger u_dut (
      .clk(clk), .rst_n(rst_n), .rep_vld(rep_vld), .rep_bank(rep_bank),
      .rep_way(rep_way), .rep_idx(rep_idx), .rep_abort(rep_abort),
      .clr_wr(clr_wr), .syn_word(syn_word));

   function automatic logic [63:0] mk(bit f, int oth, int rep, bit v,
                                      int ram, int way, int idx);
      logic [63:0] w = '0;
      w[63]    = f;
      w[47:40] = oth[7:0];
      w[39:32] = rep[7:0];
      w[31]    = v;
      w[30:24] = ram[6:0];
      w[21:18] = way[3:0];
      w[17:0]  = idx[17:0];
      return w;
   endfunction

   task automatic chk(string req, logic [63:0] exp);
      total++;
      if (syn_word !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, syn_word, exp);
      end
   endtask

   task automatic idle_in();
      rep_vld = '0; rep_abort = '0; clr_wr = 1'b0;
   endtask

   task automatic put(int p, int bank, int way, int idx, bit ab);
      rep_vld[p] = 1'b1;
      rep_abort[p] = ab;
      rep_bank[p*BW +: BW] = bank[BW-1:0];
      rep_way[p*WW +: WW]  = way[WW-1:0];
      rep_idx[p*IW +: IW]  = idx[IW-1:0];
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      idle_in();
   endtask

   task automatic clear();
      clr_wr = 1'b1;
      step();
   endtask

   task automatic t_reset();
      chk("R1 reset", 64'h0);
   endtask

   task automatic t_capture_and_count();
      put(1, 2, 5, 'h2ABCD, 0); step();
      chk("R5 capture", mk(0, 0, 0, 1, 'h11, 5, 'h2ABCD));
      for (int k = 0; k < 3; k++) begin put(1, 2, 5, 'h2ABCD, 0); step(); end
      chk("R7 repeat x3", mk(0, 0, 3, 1, 'h11, 5, 'h2ABCD));
      put(1, 1, 5, 'h2ABCD, 0); step();
      chk("R7 bank differs is other", mk(0, 1, 3, 1, 'h11, 5, 'h2ABCD));
      put(1, 2, 5, 'h2ABCE, 0); step();
      chk("R8 index differs", mk(0, 2, 3, 1, 'h11, 5, 'h2ABCD));
      put(1, 2, 5, 'h2ABCD, 0); put(3, 2, 5, 'h2ABCD, 0); step();
      chk("R8 match plus miss same cycle", mk(0, 3, 4, 1, 'h11, 5, 'h2ABCD));
      put(0, 0, 1, 7, 0); put(4, 3, 2, 9, 0); step();
      chk("R8 two misses count once", mk(0, 4, 4, 1, 'h11, 5, 'h2ABCD));
      put(2, 0, 0, 0, 1); step();
      chk("R4 fatal on later abort", mk(1, 5, 4, 1, 'h11, 5, 'h2ABCD));
      step();
      chk("R3 R4 sticky when idle", mk(1, 5, 4, 1, 'h11, 5, 'h2ABCD));
      clear();
      chk("R2 write clears", 64'h0);
   endtask

   task automatic t_clear_priority();
      put(3, 1, 2, 100, 1); clr_wr = 1'b1; step();
      chk("R2 clear beats report", 64'h0);
      put(0, 1, 15, 'h3FFFF, 1); step();
      chk("R4 first error with abort", mk(1, 0, 0, 1, 'h10, 15, 'h3FFFF));
      put(2, 0, 3, 5, 0); clr_wr = 1'b1; step();
      chk("R2 clear with valid set", 64'h0);
   endtask

   task automatic t_simul_first();
      put(4, 0, 1, 44, 0); put(2, 3, 'b0101, 'h1234, 0); step();
      chk("R9 lowest port captured", mk(0, 1, 0, 1, 'h12, 'b0101, 'h1234));
      put(2, 3, 'b0101, 'h1234, 0); step();
      chk("R5 snoop cpu/way repeat", mk(0, 1, 1, 1, 'h12, 'b0101, 'h1234));
      clear();
   endtask

   task automatic t_codes();
      int codes[5] = '{'h10, 'h11, 'h12, 'h14, 'h18};
      for (int p = 0; p < N; p++) begin
         put(p, p % 4, p + 3, p * 1000 + 1, 0); step();
         chk($sformatf("R6 port %0d code", p),
             mk(0, 0, 0, 1, codes[p], p + 3, p * 1000 + 1));
         clear();
      end
   endtask

   task automatic t_reserved();
      rep_vld = '1; rep_bank = '1; rep_way = '1; rep_idx = '1; rep_abort = '1;
      step();
      total++;
      if (syn_word[62:48] !== '0 || syn_word[23:22] !== '0) begin
         bad++;
         $display("FAIL R11: got %h expected reserved bits zero", syn_word);
      end
      chk("R9 all ports first", mk(1, 1, 0, 1, 'h10, 15, 'h3FFFF));
      clear();
   endtask

   task automatic t_saturate();
      put(3, 1, 6, 77, 0); step();
      for (int k = 0; k < 260; k++) begin put(3, 1, 6, 77, 0); step(); end
      chk("R10 repeat saturates", mk(0, 0, 255, 1, 'h14, 6, 77));
      for (int k = 0; k < 300; k++) begin put(3, 1, 6, 78, 0); step(); end
      chk("R10 other saturates", mk(0, 255, 255, 1, 'h14, 6, 77));
      put(3, 1, 6, 77, 0); put(0, 0, 0, 0, 0); step();
      chk("R10 stays at max", mk(0, 255, 255, 1, 'h14, 6, 77));
      clear();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_capture_and_count();
      t_clear_priority();
      t_simul_first();
      t_codes();
      t_reserved();
      t_saturate();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule